// File: doc/BRIEF.md
# Immediate constant load unit

This unit turns one 32-bit constant-load instruction into a register write-back. The instruction word carries an opcode, a mode flag, a sign bit, a 16-bit immediate and a 6-bit destination index. In the full mode the register receives the 17-bit value formed by the sign bit and the immediate, sign-extended to the register width. In the partial mode the register's old contents move up by 16 bits and the immediate fills the vacated low half-word. The old contents come from a register-file read port and are fed back into the write path.

With a single opcode the unit covers any register width that is a multiple of 16 and at least 32 bits. A small constant takes one full-mode load. Each further 16 bits of a wider constant takes one more partial-mode load. The unit does not hold the register file. The caller presents the destination's current value on `rd_data_i` in the same cycle as the instruction. The write-back is registered.

Top module: `imm_const_loader`

## Requirements
- R1: While `rst_n` is low, `wb_en_o` is low, and `wb_idx_o` and `wb_data_o` are zero.
- R2: An instruction is accepted only when `ins_valid_i` is high and bits [31:24] equal the `OPCODE` parameter. In every other case `wb_en_o` is low in the following cycle.
- R3: One cycle after an accepted instruction, `wb_en_o` is high and `wb_idx_o` equals the instruction's bits [5:0].
- R4: Bit 23 is the mode flag, where 0 means full and 1 means partial. Bit 22 is the sign bit, and bits [21:6] are the 16-bit immediate.
- R5: In full mode, `wb_data_o` is {sign, imm16} sign-extended to `DATA_W` bits. Any value from -65536 to 65535 can be produced this way, and `rd_data_i` has no effect.
- R6: In partial mode, `wb_data_o` is (`rd_data_i` shifted left by 16) OR imm16, and the sign bit has no effect.
- R7: In partial mode, the top 16 bits of `rd_data_i` are dropped.
- R8: A full load followed by one partial load into the same register builds any 32-bit constant. Each further partial load appends 16 more low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid_i | input | 1 | Instruction word is valid this cycle |
| ins_word_i | input | 32 | Instruction word |
| rd_data_i | input | DATA_W | Current value of the destination register |
| wb_en_o | output | 1 | Write-back enable |
| wb_idx_o | output | 6 | Write-back register index |
| wb_data_o | output | DATA_W | Write-back data |

## Verification
The assertions check the following on every cycle: enable stays low through reset, rejected instructions cause no write, an accepted instruction produces its index one cycle later, and the data follows the mode the flag selects. In full mode the checks are that the data's upper bits copy the sign bit and the low bits carry the immediate. In partial mode the checks are that the fed-back value appears shifted and the immediate appears in the low half-word. Only the bench's scenarios show the rest. These are the extremes of the full-mode range, the sign bit and the read data having no effect where they should have none, the top half-word being dropped, and multi-instruction sequences that build 32-bit and 64-bit constants through a modelled register file.

// File: rtl/immld_pkg.sv
package immld_pkg;
  localparam int INSTR_W = 32;
  localparam int IMM_W   = 16;
  localparam int IDX_W   = 6;
  localparam int OPC_W   = 8;

  // Field order is fixed by the instruction encoding (MSB first).
  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic             part;
    logic             sgn;
    logic [IMM_W-1:0] imm;
    logic [IDX_W-1:0] dst;
  } ld_instr_t;
endpackage

// File: rtl/immld_decode.sv
module immld_decode
  import immld_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPCODE = 8'h5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   word_i,
  output logic                 accept_o,
  output logic                 part_o,
  output logic                 sgn_o,
  output logic [IMM_W-1:0]     imm_o,
  output logic [IDX_W-1:0]     dst_o
);
  ld_instr_t fields;
  logic      opc_hit;

  assign fields   = ld_instr_t'(word_i);
  assign opc_hit  = (fields.opc == OPCODE);
  assign accept_o = valid_i && opc_hit;
  assign part_o   = fields.part;
  assign sgn_o    = fields.sgn;
  assign imm_o    = fields.imm;
  assign dst_o    = fields.dst;

  // R2: an accepted instruction always carries the matching opcode
  a_r2_accept_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (word_i[31:24] == OPCODE) && valid_i);
endmodule

// File: rtl/immld_value.sv
module immld_value
  import immld_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              part_i,
  input  logic              sgn_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [DATA_W-1:0] value_o
);
  localparam int EXT_W  = DATA_W - IMM_W - 1;
  localparam int KEEP_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] full_load(logic s, logic [IMM_W-1:0] imm);
    return {{EXT_W{s}}, s, imm};
  endfunction

  function automatic logic [DATA_W-1:0] partial_load(logic [DATA_W-1:0] old,
                                                     logic [IMM_W-1:0] imm);
    return {old[KEEP_W-1:0], imm};
  endfunction

  logic [DATA_W-1:0] full_v;
  logic [DATA_W-1:0] part_v;

  assign full_v  = full_load(sgn_i, imm_i);
  assign part_v  = partial_load(old_i, imm_i);
  assign value_o = part_i ? part_v : full_v;
endmodule

// File: rtl/imm_const_loader.sv
module imm_const_loader
  import immld_pkg::*;
#(
  parameter int                DATA_W = 64,
  parameter logic [OPC_W-1:0]  OPCODE = 8'h5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid_i,
  input  logic [31:0]       ins_word_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wb_en_o,
  output logic [5:0]        wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int HI_W = DATA_W - IMM_W;

  logic             accept;
  logic             part;
  logic             sgn;
  logic [IMM_W-1:0] imm;
  logic [IDX_W-1:0] dst;
  logic [DATA_W-1:0] next_value;

  immld_decode #(.OPCODE(OPCODE)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (ins_valid_i),
    .word_i   (ins_word_i),
    .accept_o (accept),
    .part_o   (part),
    .sgn_o    (sgn),
    .imm_o    (imm),
    .dst_o    (dst)
  );

  immld_value #(.DATA_W(DATA_W)) u_val (
    .part_i  (part),
    .sgn_i   (sgn),
    .imm_i   (imm),
    .old_i   (rd_data_i),
    .value_o (next_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else begin
      wb_en_o <= accept;
      if (accept) begin
        wb_idx_o  <= dst;
        wb_data_o <= next_value;
      end
    end
  end

  // R1: no write while reset is held
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !wb_en_o);

  // R2: rejected instruction produces no write
  a_r2_no_write_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !wb_en_o);

  // R3: one-cycle latency with the encoded index
  a_r3_index_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wb_en_o && (wb_idx_o == $past(ins_word_i[5:0])));

  // R5: full mode replicates the sign bit upward and carries the immediate
  a_r5_full_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ins_word_i[23]) |=>
      (wb_data_o[DATA_W-1:IMM_W] == {HI_W{$past(ins_word_i[22])}}) &&
      (wb_data_o[IMM_W-1:0] == $past(ins_word_i[21:6])));

  // R6 / R7: partial mode shifts the fed-back value and drops its top half-word
  a_r6_partial_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ins_word_i[23]) |=>
      (wb_data_o[DATA_W-1:IMM_W] == $past(rd_data_i[HI_W-1:0])) &&
      (wb_data_o[IMM_W-1:0] == $past(ins_word_i[21:6])));
endmodule

// File: tb/imm_const_loader_tb.sv
module imm_const_loader_tb;
  localparam int         W   = 64;
  localparam logic [7:0] OPC = 8'h5C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid_i = 1'b0;
  logic [31:0]   ins_word_i = '0;
  logic [W-1:0]  rd_data_i = '0;
  logic          wb_en_o;
  logic [5:0]    wb_idx_o;
  logic [W-1:0]  wb_data_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] regs [64];

  always #2.5 clk = ~clk;

  imm_const_loader #(.DATA_W(W), .OPCODE(OPC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid_i), .ins_word_i(ins_word_i),
    .rd_data_i(rd_data_i), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
  );

  function automatic logic [31:0] enc(logic [7:0] op, logic p, logic s,
                                      logic [15:0] imm, logic [5:0] r);
    return {op, p, s, imm, r};
  endfunction

  // Reference arithmetic, written independently of the design
  function automatic logic [W-1:0] ref_full(logic s, logic [15:0] imm);
    longint v;
    v = s ? (longint'(imm) - 65536) : longint'(imm);
    return W'(v);
  endfunction

  function automatic logic [W-1:0] ref_part(logic [W-1:0] old, logic [15:0] imm);
    return (old * 65536) + W'(imm);
  endfunction

  task automatic check(string req, logic en, logic [5:0] idx, logic [W-1:0] data,
                       bit chk_data);
    n_checks++;
    if (wb_en_o !== en || (en && wb_idx_o !== idx) || (chk_data && wb_data_o !== data)) begin
      n_fail++;
      $display("FAIL %s: got en=%0b idx=%0d data=%h, expected en=%0b idx=%0d data=%h",
               req, wb_en_o, wb_idx_o, wb_data_o, en, idx, data);
    end
  endtask

  // Drive at negedge, DUT captures at posedge, check at the following negedge.
  task automatic issue(logic v, logic [31:0] w, logic [W-1:0] rd);
    ins_valid_i = v;
    ins_word_i  = w;
    rd_data_i   = rd;
    @(negedge clk);
    ins_valid_i = 1'b0;
    ins_word_i  = '0;
    rd_data_i   = '0;
  endtask

  // Issue against the modelled register file and check the write-back
  task automatic load(string req, logic p, logic s, logic [15:0] imm, logic [5:0] r,
                      logic [W-1:0] exp);
    issue(1'b1, enc(OPC, p, s, imm, r), regs[r]);
    check(req, 1'b1, r, exp, 1'b1);
    if (wb_en_o) regs[wb_idx_o] = wb_data_o;
  endtask

  task automatic t_reset();
    check("R1 reset", 1'b0, 6'd0, '0, 1'b1);
  endtask

  task automatic t_full_range();
    load("R5 max positive", 1'b0, 1'b0, 16'hFFFF, 6'd3, ref_full(1'b0, 16'hFFFF));
    load("R5 most negative", 1'b0, 1'b1, 16'h0000, 6'd4, ref_full(1'b1, 16'h0000));
    load("R5 minus one", 1'b0, 1'b1, 16'hFFFF, 6'd5, {W{1'b1}});
    load("R4 R3 index 63", 1'b0, 1'b0, 16'h1234, 6'd63, 64'h1234);
  endtask

  task automatic t_full_ignores_rd();
    issue(1'b1, enc(OPC, 1'b0, 1'b0, 16'h00A5, 6'd7), {W{1'b1}});
    check("R5 rd_data ignored", 1'b1, 6'd7, 64'h00A5, 1'b1);
  endtask

  task automatic t_reject();
    issue(1'b1, enc(8'h5D, 1'b0, 1'b0, 16'h1111, 6'd2), '0);
    check("R2 wrong opcode", 1'b0, 6'd0, '0, 1'b0);
    issue(1'b0, enc(OPC, 1'b0, 1'b0, 16'h2222, 6'd2), '0);
    check("R2 not valid", 1'b0, 6'd0, '0, 1'b0);
  endtask

  task automatic t_partial_sign_ignored();
    issue(1'b1, enc(OPC, 1'b1, 1'b1, 16'h0042, 6'd9), 64'h0000_0000_0000_0001);
    check("R6 sign ignored", 1'b1, 6'd9, 64'h0000_0000_0001_0042, 1'b1);
  endtask

  task automatic t_partial_drop_top();
    issue(1'b1, enc(OPC, 1'b1, 1'b0, 16'hBEEF, 6'd10), 64'hDEAD_0123_4567_89AB);
    check("R7 top dropped", 1'b1, 6'd10, 64'h0123_4567_89AB_BEEF, 1'b1);
  endtask

  task automatic t_build_32();
    load("R8 32-bit step1", 1'b0, 1'b1, 16'hCAFE, 6'd12, ref_full(1'b1, 16'hCAFE));
    load("R8 32-bit step2", 1'b1, 1'b0, 16'hF00D, 6'd12, ref_part(regs[12], 16'hF00D));
    n_checks++;
    if (regs[12][31:0] !== 32'hCAFE_F00D) begin
      n_fail++;
      $display("FAIL R8 32-bit constant: got %h, expected %h", regs[12][31:0], 32'hCAFEF00D);
    end
  endtask

  task automatic t_build_64();
    load("R8 64-bit step1", 1'b0, 1'b0, 16'h0123, 6'd20, ref_full(1'b0, 16'h0123));
    load("R8 64-bit step2", 1'b1, 1'b0, 16'h4567, 6'd20, ref_part(regs[20], 16'h4567));
    load("R8 64-bit step3", 1'b1, 1'b0, 16'h89AB, 6'd20, ref_part(regs[20], 16'h89AB));
    load("R8 64-bit step4", 1'b1, 1'b0, 16'hCDEF, 6'd20, ref_part(regs[20], 16'hCDEF));
    n_checks++;
    if (regs[20] !== 64'h0123_4567_89AB_CDEF) begin
      n_fail++;
      $display("FAIL R8 64-bit constant: got %h, expected %h", regs[20], 64'h0123456789ABCDEF);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_range();
    t_full_ignores_rd();
    t_reject();
    t_partial_sign_ignored();
    t_partial_drop_top();
    t_build_32();
    t_build_64();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule